// File: doc/BRIEF.md
# Downlink Command Frame Assembler

This block turns one downlink command for a low-frequency contactless tag into the ordered stream of bits that a gap modulator sends, one symbol at a time. A one-cycle start pulse captures the command description: the downlink mode, the password, page, test, reset, register-read and read flags, a 32-bit password, a 32-bit data word and a 3-bit block address. The block assembles the whole frame into an internal buffer and then presents it over a valid/ready handshake.

In three of the four modes each symbol is a single bit. In the one-of-four mode each symbol is a pair of consecutive bits, and the modulator chooses one of four pulse widths from it. While a frame is in flight the block also reports its total length in bits, so that the timing stage can plan its duration. Pulse timing and decoding of the tag's answer belong to other blocks.

Top module: `dl_frame_assembler`

## Requirements
- R1: Reference bits come first and depend on `mode_i`. Mode 0 (fixed) and mode 1 (long leading reference) send none. Mode 2 (leading zero) sends one 0. Mode 3 (one-of-four) sends two 0s.
- R2: When `reset_cmd_i` is set, the frame is the reference bits followed by the opcode 00 and nothing else, whatever the other flags say.
- R3: Otherwise a two-bit opcode follows the reference bits. It is 1 then `page_i`, or 0 then 1 when `test_i` is set.
- R4: With `pwd_mode_i` set, the opcode is followed by two 0 bits in modes 2 and 3 only, and then by `password_i` with its MSB first.
- R5: A single 0 lock bit comes next, unless `reg_read_i` is set.
- R6: When `read_i` is clear, `data_i` follows with its MSB first. When `read_i` is set, the data word is left out.
- R7: The frame ends with `block_i`, MSB first, unless `reg_read_i` is set.
- R8: In modes 0 to 2 each symbol carries its bit in `sym_o[0]`, `sym_o[1]` is 0 and `sym_pair_o` is 0. In mode 3, `sym_pair_o` is 1 and each symbol carries two consecutive bits, the earlier one in `sym_o[1]`. A trailing odd bit is never sent.
- R9: A symbol with `sym_valid_o` high and `sym_ready_i` low stays valid and unchanged in the next cycle. The stream advances only when a symbol is accepted.
- R10: `busy_o` rises in the cycle after an accepted start. It falls in the cycle after the last symbol is accepted. While busy, `frame_len_o` holds the frame's bit count. While idle, `frame_len_o` is 0 and `sym_valid_o` is low.
- R11: A start pulse while busy is ignored. It neither changes the current frame nor queues a new one.
- R12: After reset the block is idle: `busy_o`, `sym_valid_o` and `frame_len_o` are all 0.
- R13: The longest frame is a mode 3 password write of 74 bits, and it fits the 80-bit buffer intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to assemble a frame |
| mode_i | input | 2 | Downlink mode: 0 fixed, 1 long reference, 2 leading zero, 3 one-of-four |
| pwd_mode_i | input | 1 | Include the password field |
| page_i | input | 1 | Page bit of the normal opcode |
| test_i | input | 1 | Use the test opcode |
| reset_cmd_i | input | 1 | Build a reset command |
| reg_read_i | input | 1 | Register-read form: no lock bit, no address |
| read_i | input | 1 | Read command: no data word |
| password_i | input | 32 | Password value |
| data_i | input | 32 | Data word to write |
| block_i | input | 3 | Block address |
| sym_valid_o | output | 1 | A symbol is offered |
| sym_ready_i | input | 1 | The modulator takes the offered symbol |
| sym_o | output | 2 | Symbol: a bit pair, or a single bit in bit 0 |
| sym_pair_o | output | 1 | The current frame uses bit pairs |
| frame_len_o | output | 7 | Bit count of the frame in flight |
| busy_o | output | 1 | A frame is in flight |

## Verification
A field pushed with the wrong width or in the wrong place shifts every later bit. The first bad symbol therefore shows up at the field boundary, and `frame_len_o` is already wrong in the first busy cycle. A remaining-bit count that is off by one ends the frame a symbol early or late. That appears at the last handshake as a missing or extra symbol, and in mode 3 as a stuck `busy_o` when one bit is left over. A shift register that moves on a stalled cycle drops a symbol, and this shows up in the very next cycle because the offered symbol changes without an acceptance.

// File: rtl/dl_frame_pkg.sv
`timescale 1ns/1ps
package dl_frame_pkg;

  typedef enum logic [1:0] {
    DL_FIXED   = 2'd0,
    DL_LONGREF = 2'd1,
    DL_LEAD0   = 2'd2,
    DL_QUAD    = 2'd3
  } dl_mode_e;

  typedef struct packed {
    dl_mode_e mode;
    logic     pwd_en;
    logic     page;
    logic     test;
    logic     reset;
    logic     reg_read;
    logic     read;
  } dl_flags_t;

  // Number of leading zero reference bits for a mode
  function automatic int dl_ref_bits(dl_mode_e m);
    return (m == DL_QUAD) ? 2 : ((m == DL_LEAD0) ? 1 : 0);
  endfunction

  // Frame length, computed field by field from the flags alone
  function automatic int dl_frame_bits(dl_flags_t f, int word_w, int addr_w);
    int n;
    n = dl_ref_bits(f.mode) + 2;
    if (!f.reset) begin
      if (f.pwd_en)
        n += word_w + ((f.mode == DL_LEAD0 || f.mode == DL_QUAD) ? 2 : 0);
      if (!f.reg_read) n += 1 + addr_w;
      if (!f.read)     n += word_w;
    end
    return n;
  endfunction

endpackage

// File: rtl/dl_frame_builder.sv
`timescale 1ns/1ps
module dl_frame_builder
  import dl_frame_pkg::*;
#(
  parameter int BUF_W  = 80,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  localparam int LEN_W = $clog2(BUF_W + 1)
) (
  input  dl_flags_t          flags_i,
  input  logic [WORD_W-1:0]  password_i,
  input  logic [WORD_W-1:0]  data_i,
  input  logic [ADDR_W-1:0]  block_i,
  output logic [BUF_W-1:0]   frame_o,
  output logic [LEN_W-1:0]   len_o
);

  // Append the low w bits of v to the right end of the accumulator
  function automatic logic [BUF_W-1:0] push(input logic [BUF_W-1:0] acc,
                                            input logic [WORD_W-1:0] v,
                                            input int unsigned w);
    logic [BUF_W-1:0] mask;
    mask = (BUF_W'(1) << w) - BUF_W'(1);
    return (acc << w) | (BUF_W'(v) & mask);
  endfunction

  logic [BUF_W-1:0] acc;
  int unsigned      nbits;
  logic             lead_style;

  always_comb begin
    acc        = '0;
    nbits      = 0;
    lead_style = (flags_i.mode == DL_LEAD0) || (flags_i.mode == DL_QUAD);
    if (lead_style) begin
      acc = push(acc, '0, 1); nbits += 1;
    end
    if (flags_i.mode == DL_QUAD) begin
      acc = push(acc, '0, 1); nbits += 1;
    end
    if (flags_i.reset) begin
      acc = push(acc, '0, 2); nbits += 2;
    end else begin
      acc = push(acc, flags_i.test ? WORD_W'(2'b01) : WORD_W'({1'b1, flags_i.page}), 2);
      nbits += 2;
      if (flags_i.pwd_en) begin
        if (lead_style) begin
          acc = push(acc, '0, 2); nbits += 2;
        end
        acc = push(acc, password_i, WORD_W); nbits += WORD_W;
      end
      if (!flags_i.reg_read) begin
        acc = push(acc, '0, 1); nbits += 1;
      end
      if (!flags_i.read) begin
        acc = push(acc, data_i, WORD_W); nbits += WORD_W;
      end
      if (!flags_i.reg_read) begin
        acc = push(acc, WORD_W'(block_i), ADDR_W); nbits += ADDR_W;
      end
    end
    len_o   = LEN_W'(nbits);
    frame_o = acc << (BUF_W - nbits);
  end

endmodule

// File: rtl/dl_sym_sequencer.sv
`timescale 1ns/1ps
module dl_sym_sequencer #(
  parameter int BUF_W  = 80,
  localparam int LEN_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUF_W-1:0] frame_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pair_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [1:0]       sym_o,
  output logic             pair_o,
  output logic [LEN_W-1:0] len_o,
  output logic             busy_o,
  output logic             accept_o,
  output logic             last_o
);

  logic [BUF_W-1:0] sr_q;
  logic [LEN_W-1:0] left_q, total_q, step, step_ld;
  logic             pair_q, busy_q;

  assign step     = pair_q ? LEN_W'(2) : LEN_W'(1);
  assign step_ld  = pair_i ? LEN_W'(2) : LEN_W'(1);
  assign valid_o  = busy_q && (left_q >= step);
  assign accept_o = valid_o && ready_i;
  assign last_o   = accept_o && (left_q < (step << 1));
  assign sym_o    = pair_q ? sr_q[BUF_W-1 -: 2] : {1'b0, sr_q[BUF_W-1]};
  assign pair_o   = busy_q && pair_q;
  assign len_o    = busy_q ? total_q : '0;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      left_q  <= '0;
      total_q <= '0;
      pair_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      sr_q    <= frame_i;
      left_q  <= len_i;
      total_q <= len_i;
      pair_q  <= pair_i;
      busy_q  <= (len_i >= step_ld);
    end else if (accept_o) begin
      sr_q   <= pair_q ? (sr_q << 2) : (sr_q << 1);
      left_q <= left_q - step;
      if (last_o) busy_q <= 1'b0;
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(sym_o));

  // R8
  single_bit_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !pair_q |-> sym_o[1] == 1'b0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !valid_o && len_o == '0);

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_o |=> busy_o && $stable(len_o));

endmodule

// File: rtl/dl_frame_assembler.sv
`timescale 1ns/1ps
module dl_frame_assembler
  import dl_frame_pkg::*;
#(
  parameter int BUF_W  = 80,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  localparam int LEN_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              pwd_mode_i,
  input  logic              page_i,
  input  logic              test_i,
  input  logic              reset_cmd_i,
  input  logic              reg_read_i,
  input  logic              read_i,
  input  logic [WORD_W-1:0] password_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [ADDR_W-1:0] block_i,
  output logic              sym_valid_o,
  input  logic              sym_ready_i,
  output logic [1:0]        sym_o,
  output logic              sym_pair_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              busy_o
);

  dl_flags_t        flags;
  logic [BUF_W-1:0] bld_frame;
  logic [LEN_W-1:0] bld_len;
  logic             start_take;
  logic             seq_accept, seq_last;

  always_comb begin
    flags.mode     = dl_mode_e'(mode_i);
    flags.pwd_en   = pwd_mode_i;
    flags.page     = page_i;
    flags.test     = test_i;
    flags.reset    = reset_cmd_i;
    flags.reg_read = reg_read_i;
    flags.read     = read_i;
  end

  assign start_take = start_i && !busy_o;

  dl_frame_builder #(.BUF_W(BUF_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) builder_i (
    .flags_i    (flags),
    .password_i (password_i),
    .data_i     (data_i),
    .block_i    (block_i),
    .frame_o    (bld_frame),
    .len_o      (bld_len)
  );

  dl_sym_sequencer #(.BUF_W(BUF_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_take),
    .frame_i  (bld_frame),
    .len_i    (bld_len),
    .pair_i   (flags.mode == DL_QUAD),
    .ready_i  (sym_ready_i),
    .valid_o  (sym_valid_o),
    .sym_o    (sym_o),
    .pair_o   (sym_pair_o),
    .len_o    (frame_len_o),
    .busy_o   (busy_o),
    .accept_o (seq_accept),
    .last_o   (seq_last)
  );

  // R13
  len_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |-> (int'(bld_len) == dl_frame_bits(flags, WORD_W, ADDR_W))
                   && (int'(bld_len) <= BUF_W));

  // R11
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && !seq_last |=> busy_o && $stable(frame_len_o));

  // R10
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> busy_o && !seq_accept || busy_o);

endmodule

// File: tb/dl_frame_assembler_tb_top.sv
`timescale 1ns/1ps
module dl_frame_assembler_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        pwd_mode_i = 1'b0, page_i = 1'b0, test_i = 1'b0;
  logic        reset_cmd_i = 1'b0, reg_read_i = 1'b0, read_i = 1'b0;
  logic [31:0] password_i = '0, data_i = '0;
  logic [2:0]  block_i = '0;
  logic        sym_valid_o, sym_ready_i = 1'b0, sym_pair_o, busy_o;
  logic [1:0]  sym_o;
  logic [6:0]  frame_len_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dl_frame_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .pwd_mode_i(pwd_mode_i), .page_i(page_i), .test_i(test_i),
    .reset_cmd_i(reset_cmd_i), .reg_read_i(reg_read_i), .read_i(read_i),
    .password_i(password_i), .data_i(data_i), .block_i(block_i),
    .sym_valid_o(sym_valid_o), .sym_ready_i(sym_ready_i), .sym_o(sym_o),
    .sym_pair_o(sym_pair_o), .frame_len_o(frame_len_o), .busy_o(busy_o)
  );

  // {req[15:12], mode[11:10], pwd[9], page[8], test[7], rst[6], rr[5], rd[4], 0, blk[2:0]}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {4'd6,  2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd5},
    {4'd3,  2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'd3},
    {4'd3,  2'd1, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0, 3'd6},
    {4'd1,  2'd2, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd1},
    {4'd8,  2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd7},
    {4'd2,  2'd0, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0, 3'd4},
    {4'd2,  2'd3, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0, 3'd2},
    {4'd4,  2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 3'd6},
    {4'd13, 2'd3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd5},
    {4'd5,  2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0, 3'd7},
    {4'd7,  2'd2, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0, 3'd3},
    {4'd4,  2'd1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 3'd1}
  };

  function automatic string req_name(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      13: return "R13";
      default: return "R?";
    endcase
  endfunction

  // Independent reference model: an ordered bit list
  logic eb [80];
  int   en;

  task automatic put(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      eb[en] = v[k];
      en++;
    end
  endtask

  task automatic model();
    en = 0;
    if (mode_i >= 2) put(0, mode_i - 1);   // R1 reference zeros
    if (reset_cmd_i) put(0, 2);            // R2
    else begin
      if (test_i) put(1, 2); else put({31'd1, page_i}, 2);  // R3
      if (pwd_mode_i) begin
        if (mode_i >= 2) put(0, 2);        // R4
        put(password_i, 32);
      end
      if (!reg_read_i) put(0, 1);          // R5
      if (!read_i) put(data_i, 32);        // R6
      if (!reg_read_i) put({29'd0, block_i}, 3);  // R7
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v, input int idx);
    mode_i      = v[11:10];
    pwd_mode_i  = v[9];
    page_i      = v[8];
    test_i      = v[7];
    reset_cmd_i = v[6];
    reg_read_i  = v[5];
    read_i      = v[4];
    block_i     = v[2:0];
    password_i  = 32'h8000_0001 ^ (idx * 32'h1357_9BDF);
    data_i      = {password_i[15:0], password_i[31:16]} ^ 32'hF0F0_0FF0;
  endtask

  // Drains the frame in flight; compares it with the model captured at start
  task automatic drain(input string req, input int stall_mod);
    int   nsym, idx, bad, unstable, guard;
    logic [1:0] exp_sym, held;
    logic was_stalled, rdy, pair;
    pair  = (mode_i == 2'd3);
    nsym  = pair ? en / 2 : en;
    idx = 0; bad = 0; unstable = 0; guard = 0; was_stalled = 0; held = '0;
    while (busy_o && guard < 400) begin
      rdy = (stall_mod == 0) ? 1'b1 : ((guard % stall_mod) != 1);
      sym_ready_i = rdy;
      if (was_stalled && (!sym_valid_o || sym_o !== held)) unstable++;
      if (sym_valid_o && rdy) begin
        exp_sym = pair ? {eb[2*idx], eb[2*idx+1]} : {1'b0, eb[idx]};
        if (idx >= nsym || sym_o !== exp_sym || sym_pair_o !== pair) begin
          if (bad == 0)
            $display("FAIL %s symbol %0d actual=%0d expected=%0d", req, idx, sym_o, exp_sym);
          bad++;
        end
        idx++;
      end
      was_stalled = sym_valid_o && !rdy;
      held = sym_o;
      guard++;
      @(negedge clk);
    end
    sym_ready_i = 1'b0;
    checks++;
    if (bad != 0) fails++;
    chk(unstable == 0, "R9", "stalled symbol changed count", unstable, 0);
    chk(idx == nsym, req, "symbol count", idx, nsym);
  endtask

  task automatic launch();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=busy expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy_o == 1'b0 && sym_valid_o == 1'b0 && frame_len_o == '0, "R12",
        "idle during reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && sym_valid_o == 1'b0 && frame_len_o == '0, "R12",
        "idle after reset", int'(frame_len_o), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], i);
      model();
      launch();
      // R10 length visible in the cycle after start
      chk(busy_o && int'(frame_len_o) == en, "R10", "frame length", int'(frame_len_o), en);
      drain(req_name(int'(VEC[i][15:12])), 3);
      chk(!busy_o && frame_len_o == '0, "R10", "idle after frame", int'(busy_o), 0);
      if (VEC[i][15:12] == 4'd13)
        chk(en == 74, "R13", "longest frame bits", en, 74);
      @(negedge clk);
    end

    // R9 long stall holds the first symbol and the length
    apply(VEC[0], 20);
    model();
    launch();
    begin
      logic [1:0] s0;
      int moved;
      s0 = sym_o;
      moved = 0;
      repeat (6) begin
        @(negedge clk);
        if (!sym_valid_o || sym_o !== s0 || int'(frame_len_o) != en) moved++;
      end
      chk(moved == 0 && s0 == {1'b0, eb[0]}, "R9", "hold under long stall", moved, 0);
    end
    drain("R9", 0);

    // R11 start while busy is ignored
    mode_i = 2'd0; pwd_mode_i = 0; page_i = 0; test_i = 0; reset_cmd_i = 0;
    reg_read_i = 0; read_i = 1; block_i = 3'd2;
    model();
    launch();
    begin
      logic eb_a [80];
      int   en_a, idx, bad, guard, after;
      logic [1:0] m_a;
      en_a = en;
      foreach (eb_a[k]) eb_a[k] = eb[k];
      m_a = mode_i;
      // second request with a different shape, one cycle, mid frame
      mode_i = 2'd3; reset_cmd_i = 1'b1;
      start_i = 1'b1;
      sym_ready_i = 1'b1;
      idx = 0; bad = 0; guard = 0;
      while (busy_o && guard < 100) begin
        if (sym_valid_o) begin
          if (idx >= en_a || sym_o !== {1'b0, eb_a[idx]} || sym_pair_o) bad++;
          idx++;
        end
        if (int'(frame_len_o) != en_a) bad++;
        guard++;
        @(negedge clk);
        start_i = 1'b0;
      end
      sym_ready_i = 1'b0;
      chk(bad == 0 && idx == en_a && m_a == 2'd0, "R11", "frame kept despite start",
          bad, 0);
      after = 0;
      repeat (3) begin
        @(negedge clk);
        if (busy_o || sym_valid_o) after++;
      end
      chk(after == 0, "R11", "no queued frame", after, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule